// File: doc/BRIEF.md
# Voice Path Frame Delay Controller

This block manages the sample paths around a pair of echo-cancelling filter cores on a framed TDM voice interface. Once per frame it takes a receive-side sample and a send-side sample for each of two lanes. It passes them to the two cores and collects the processed results. It delivers receive and send output samples after a fixed number of frames, and that number depends on whether bypass is active. Mute controls replace an output with a programmable quiet code. A topology setting routes the samples in one of three ways. The two cores can work on two independent channels, or on one channel in opposite directions, or cascaded as one canceller of double length. A narrow side channel for signalling data is carried on its own one-frame path.

Frame boundaries come from a single-cycle frame pulse, and every delay stage moves only on that pulse. An active-low power-down input freezes all sequencing. It drops the output enable for the sample and side outputs, so the pad ring can float them, and it forces the frame-strobe outputs to their idle high level. After release, the block spends exactly one frame in initialisation. During that frame it loads default settings and clears the pipelines.

Top module: `vpd_frame_ctl`

## Requirements
- R1: Outside bypass, the receive sample captured at a frame pulse appears on `rxOut` two frame pulses later. All output and stage registers change only at a frame pulse, or while being cleared during initialisation.
- R2: Outside bypass, the send sample captured at a frame pulse leaves `txOut` three frame pulses later, as the core result of that sample.
- R3: While bypass is active, both paths skip the cores and take exactly two frames. `rxOut` shows the captured receive sample and `txOut` shows the captured send sample.
- R4: At the frame pulse where bypass changes state, every stage and output register loads the quiet code that was in force before that pulse.
- R5: Mute-send forces `txOut` to the quiet code, and mute-receive forces `rxOut` to the quiet code. The quiet code defaults to zero.
- R6: Configuration written mid-frame takes effect only at the next frame pulse. An output loaded at a pulse uses the settings in force before that pulse.
- R7: Each side-channel value captured at a frame pulse appears on `sideOut` one frame pulse later.
- R8: While `pwrDnN` is low, `dataOe` is low, `fpOutN` and both `tsOutN` bits are high, and no setting or stage changes.
- R9: After reset or power-down release, the first frame pulse starts an initialisation frame and the second frame pulse ends it. Until then, `dataOe` is low, settings are held at their defaults, writes are ignored, and stages read zero.
- R10: `cfgTopo` selects the topology, and lane l uses bits [l*W +: W]. 0 is Normal: lane l uses core l and the receive path bypasses the cores. 1 is Back-to-Back: core 0 takes reference rx0 and signal tx0, and gives the send result; core 1 takes reference tx0 and signal rx0, and gives the receive result. 2 is Extended: core 1 takes reference rx0 and signal core-0 result, and gives the send result. 3 acts as Normal. Outside Normal, lane 1 outputs the quiet code.
- R11: `coreAdaptOff` presents the adaptation-disable setting to both cores. It changes only at frame pulses and does not alter any latency.
- R12: `fpOutN` goes low for one cycle in the cycle after a frame pulse in run. `tsOutN[0]` then goes low for the next cycle, and `tsOutN[1]` for the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Active-low power-down |
| framePulse | input | 1 | Single-cycle frame boundary pulse |
| cfgWe | input | 1 | Write strobe for the settings below |
| cfgMuteSend | input | 1 | Mute send output |
| cfgMuteRecv | input | 1 | Mute receive output |
| cfgBypass | input | 1 | Bypass the cores |
| cfgAdaptOff | input | 1 | Adaptation-disable for the cores |
| cfgTopo | input | 2 | Topology code |
| cfgQuiet | input | W | Quiet code |
| rxIn | input | 2*W | Receive samples, two lanes |
| txIn | input | 2*W | Send samples, two lanes |
| sideIn | input | SW | Side-channel input |
| coreRes | input | 2*W | Processed results from cores 0 and 1 |
| rxOut | output | 2*W | Receive output samples |
| txOut | output | 2*W | Send output samples |
| sideOut | output | SW | Side-channel output |
| dataOe | output | 1 | Output enable for rxOut, txOut and sideOut |
| fpOutN | output | 1 | Active-low frame strobe |
| tsOutN | output | 2 | Active-low timeslot strobes |
| coreRef | output | 2*W | Reference sample to each core |
| coreSig | output | 2*W | Signal sample to each core |
| coreAdaptOff | output | 1 | Held adaptation-disable flag |

## Verification
The assertions check three things on every cycle. Stage and output registers stay frozen between frame pulses, the active settings do not move mid-frame or during power-down, and a bypass flush leaves the quiet code in the outputs. The strobes are also checked to be idle whenever the outputs are disabled. Only the bench scenarios can show the two-frame and three-frame latencies, the routing of each topology through the modelled cores, the mute substitution, and that the initialisation frame lasts exactly one frame while discarding writes.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    TOPO_NORMAL = 2'd0,
    TOPO_B2B    = 2'd1,
    TOPO_EXT    = 2'd2,
    TOPO_RSVD   = 2'd3
  } topo_e;

  typedef struct packed {
    logic  muteSend;
    logic  muteRecv;
    logic  bypass;
    logic  adaptOff;
    topo_e topo;
  } ctlBits_t;

  typedef struct packed {
    logic advance;
    logic flush;
    logic clear;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_PWRDN = 2'd0,
    ST_ARM   = 2'd1,
    ST_INIT  = 2'd2,
    ST_RUN   = 2'd3
  } pstate_e;
endpackage

// File: rtl/vpd_ctrl.sv
module vpd_ctrl
  import vpd_pkg::*;
#(
  parameter int W      = 8,
  parameter int NUM_TS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDnN,
  input  logic              framePulse,
  input  logic              cfgWe,
  input  ctlBits_t          cfgBits,
  input  logic [W-1:0]      cfgQuiet,
  output strobe_t           strb,
  output ctlBits_t          actBits,
  output logic [W-1:0]      actQuiet,
  output logic              running,
  output logic              fpOutN,
  output logic [NUM_TS-1:0] tsOutN
);
  localparam ctlBits_t DEF_BITS = ctlBits_t'('0);
  localparam int SR_LEN = NUM_TS + 1;

  pstate_e           state, stateNext;
  ctlBits_t          regBits;
  logic [W-1:0]      regQuiet;
  logic [SR_LEN-1:0] pulseSr;
  logic              initLike;

  assign initLike     = pwrDnN && (state == ST_ARM || state == ST_INIT);
  assign running      = pwrDnN && (state == ST_RUN);
  assign strb.advance = running && framePulse;
  assign strb.flush   = strb.advance && (regBits.bypass != actBits.bypass);
  assign strb.clear   = initLike;

  always_comb begin
    stateNext = state;
    if (!pwrDnN) stateNext = ST_PWRDN;
    else begin
      unique case (state)
        ST_PWRDN: stateNext = ST_ARM;
        ST_ARM:   if (framePulse) stateNext = ST_INIT;
        ST_INIT:  if (framePulse) stateNext = ST_RUN;
        default:  stateNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ARM;
      regBits  <= DEF_BITS;
      regQuiet <= '0;
      actBits  <= DEF_BITS;
      actQuiet <= '0;
    end else begin
      state <= stateNext;
      if (initLike) begin
        regBits  <= DEF_BITS;
        regQuiet <= '0;
        actBits  <= DEF_BITS;
        actQuiet <= '0;
      end else if (running) begin
        if (strb.advance) begin
          actBits  <= regBits;
          actQuiet <= regQuiet;
        end
        if (cfgWe) begin
          regBits  <= cfgBits;
          regQuiet <= cfgQuiet;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseSr <= '0;
    else if (running) pulseSr <= {pulseSr[SR_LEN-2:0], strb.advance};
    else if (initLike) pulseSr <= '0;
  end

  assign fpOutN = !(running && pulseSr[0]);
  for (genvar i = 0; i < NUM_TS; i++) begin : gTs
    assign tsOutN[i] = !(running && pulseSr[i+1]);
  end

  // R8: a low power-down input freezes every setting
  assert_pd_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> ($stable(actBits) && $stable(regBits) && $stable(actQuiet)));

  // R6: in run, active settings only move at a frame pulse
  assert_cfg_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !strb.advance) |=> ($stable(actBits) && $stable(actQuiet)));
endmodule

// File: rtl/vpd_path.sv
module vpd_path
  import vpd_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  ctlBits_t              actBits,
  input  logic [W-1:0]          actQuiet,
  input  logic [LANES-1:0][W-1:0] rxIn,
  input  logic [LANES-1:0][W-1:0] txIn,
  input  logic [LANES-1:0][W-1:0] coreRes,
  input  logic [SW-1:0]         sideIn,
  output logic [LANES-1:0][W-1:0] rxOut,
  output logic [LANES-1:0][W-1:0] txOut,
  output logic [LANES-1:0][W-1:0] coreRef,
  output logic [LANES-1:0][W-1:0] coreSig,
  output logic [SW-1:0]         sideOut
);
  logic [LANES-1:0][W-1:0] rxStage, txStage, txMid, rxOutR, txOutR;
  logic [LANES-1:0][W-1:0] sendProc, recvVal;
  logic [LANES-1:0]        laneUsed;
  logic [SW-1:0]           sideR;
  logic                    isB2B, isExt;

  assign isB2B = (actBits.topo == TOPO_B2B);
  assign isExt = (actBits.topo == TOPO_EXT);

  for (genvar l = 0; l < LANES; l++) begin : gUse
    if (l == 0) begin : gFirst
      assign laneUsed[l] = 1'b1;
    end else begin : gOther
      assign laneUsed[l] = !(isB2B || isExt);
    end
  end

  always_comb begin
    coreRef  = rxStage;
    coreSig  = txStage;
    sendProc = coreRes;
    recvVal  = rxStage;
    if (isB2B) begin
      coreRef[1] = txStage[0];
      coreSig[1] = rxStage[0];
      if (!actBits.bypass) recvVal[0] = coreRes[1];
    end else if (isExt) begin
      coreRef[1]  = rxStage[0];
      coreSig[1]  = coreRes[0];
      sendProc[0] = coreRes[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStage <= '0; txStage <= '0; txMid <= '0;
      rxOutR  <= '0; txOutR  <= '0; sideR <= '0;
    end else if (strb.clear) begin
      rxStage <= '0; txStage <= '0; txMid <= '0;
      rxOutR  <= '0; txOutR  <= '0; sideR <= '0;
    end else if (strb.advance) begin
      sideR <= sideIn;
      for (int l = 0; l < LANES; l++) begin
        rxStage[l] <= strb.flush ? actQuiet : rxIn[l];
        txStage[l] <= strb.flush ? actQuiet : txIn[l];
        txMid[l]   <= (strb.flush || !laneUsed[l]) ? actQuiet : sendProc[l];
        rxOutR[l]  <= (strb.flush || !laneUsed[l] || actBits.muteRecv) ? actQuiet : recvVal[l];
        txOutR[l]  <= (strb.flush || !laneUsed[l] || actBits.muteSend) ? actQuiet
                      : (actBits.bypass ? txStage[l] : txMid[l]);
      end
    end
  end

  assign rxOut   = rxOutR;
  assign txOut   = txOutR;
  assign sideOut = sideR;

  // R1: outputs and stages hold between frame pulses
  assert_hold_between_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.clear) |=> ($stable(rxOutR) && $stable(txOutR) && $stable(txMid)
                                       && $stable(rxStage) && $stable(txStage)));

  // R4: a bypass change leaves the quiet code everywhere
  assert_flush_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (rxOutR[0] == $past(actQuiet) && txOutR[0] == $past(actQuiet)
                    && txStage[0] == $past(actQuiet) && rxStage[0] == $past(actQuiet)));
endmodule

// File: rtl/vpd_frame_ctl.sv
module vpd_frame_ctl
  import vpd_pkg::*;
#(
  parameter int W       = 8,
  parameter int SW      = 4,
  parameter int TS_OUTS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 framePulse,
  input  logic                 cfgWe,
  input  logic                 cfgMuteSend,
  input  logic                 cfgMuteRecv,
  input  logic                 cfgBypass,
  input  logic                 cfgAdaptOff,
  input  logic [1:0]           cfgTopo,
  input  logic [W-1:0]         cfgQuiet,
  input  logic [LANES*W-1:0]   rxIn,
  input  logic [LANES*W-1:0]   txIn,
  input  logic [SW-1:0]        sideIn,
  input  logic [LANES*W-1:0]   coreRes,
  output logic [LANES*W-1:0]   rxOut,
  output logic [LANES*W-1:0]   txOut,
  output logic [SW-1:0]        sideOut,
  output logic                 dataOe,
  output logic                 fpOutN,
  output logic [TS_OUTS-1:0]   tsOutN,
  output logic [LANES*W-1:0]   coreRef,
  output logic [LANES*W-1:0]   coreSig,
  output logic                 coreAdaptOff
);
  ctlBits_t cfgBits, actBits;
  strobe_t  strb;
  logic [W-1:0] actQuiet;
  logic running;
  logic [LANES-1:0][W-1:0] rxArr, txArr, resArr, rxOutArr, txOutArr, refArr, sigArr;

  assign cfgBits = '{muteSend: cfgMuteSend, muteRecv: cfgMuteRecv, bypass: cfgBypass,
                     adaptOff: cfgAdaptOff, topo: topo_e'(cfgTopo)};
  assign rxArr  = rxIn;
  assign txArr  = txIn;
  assign resArr = coreRes;

  vpd_ctrl #(.W(W), .NUM_TS(TS_OUTS)) uCtrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .framePulse(framePulse),
    .cfgWe(cfgWe), .cfgBits(cfgBits), .cfgQuiet(cfgQuiet),
    .strb(strb), .actBits(actBits), .actQuiet(actQuiet), .running(running),
    .fpOutN(fpOutN), .tsOutN(tsOutN)
  );

  vpd_path #(.W(W), .SW(SW)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .actBits(actBits), .actQuiet(actQuiet),
    .rxIn(rxArr), .txIn(txArr), .coreRes(resArr), .sideIn(sideIn),
    .rxOut(rxOutArr), .txOut(txOutArr), .coreRef(refArr), .coreSig(sigArr),
    .sideOut(sideOut)
  );

  assign rxOut        = rxOutArr;
  assign txOut        = txOutArr;
  assign coreRef      = refArr;
  assign coreSig      = sigArr;
  assign dataOe       = running;
  assign coreAdaptOff = actBits.adaptOff;

  // R12: strobes stay idle whenever the outputs are disabled
  assert_strobe_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (fpOutN && (&tsOutN)));
endmodule

// File: tb/vpd_frame_ctl_test.sv
module vpd_frame_ctl_test;
  localparam int W = 8;
  localparam int SW = 4;

  logic clk = 0, rstN = 0, pwrDnN = 1, framePulse = 0, cfgWe = 0;
  logic cfgMuteSend = 0, cfgMuteRecv = 0, cfgBypass = 0, cfgAdaptOff = 0;
  logic [1:0] cfgTopo = 0;
  logic [W-1:0] cfgQuiet = 0;
  logic [2*W-1:0] rxIn = 0, txIn = 0, coreRes, rxOut, txOut, coreRef, coreSig;
  logic [SW-1:0] sideIn = 0, sideOut;
  logic dataOe, fpOutN, coreAdaptOff;
  logic [1:0] tsOutN;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] core0(input logic [7:0] x); return x + 8'h11; endfunction
  function automatic logic [7:0] core1(input logic [7:0] x); return x ^ 8'h5A; endfunction

  assign coreRes[7:0]  = core0(coreSig[7:0]);
  assign coreRes[15:8] = core1(coreSig[15:8]);

  vpd_frame_ctl #(.W(W), .SW(SW), .TS_OUTS(2)) uut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .framePulse(framePulse), .cfgWe(cfgWe),
    .cfgMuteSend(cfgMuteSend), .cfgMuteRecv(cfgMuteRecv), .cfgBypass(cfgBypass),
    .cfgAdaptOff(cfgAdaptOff), .cfgTopo(cfgTopo), .cfgQuiet(cfgQuiet),
    .rxIn(rxIn), .txIn(txIn), .sideIn(sideIn), .coreRes(coreRes),
    .rxOut(rxOut), .txOut(txOut), .sideOut(sideOut), .dataOe(dataOe),
    .fpOutN(fpOutN), .tsOutN(tsOutN), .coreRef(coreRef), .coreSig(coreSig),
    .coreAdaptOff(coreAdaptOff)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // stimulus: frame pulse every 8 cycles and changing data
  int fcnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1;
    framePulse = (fcnt == 7);
    fcnt = (fcnt + 1) % 8;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rxIn = {lfsr[7:0], lfsr[15:8]};
    txIn = {lfsr[11:4], lfsr[3:0], lfsr[15:12]};
    sideIn = lfsr[9:6];
  end

  // behavioural reference model
  int mSt;                       // 0 power-down, 1 arm, 2 init, 3 run
  bit rMs, rMr, rBy, rAd, aMs, aMr, aBy, aAd;
  int rTopo, aTopo;
  logic [7:0] rQ, aQ;
  logic [7:0] mR0[2], mS0[2], mS1[2], mRo[2], mTo[2];
  logic [3:0] mSide;
  bit mP[3];

  task automatic modelClear();
    rMs = 0; rMr = 0; rBy = 0; rAd = 0; rTopo = 0; rQ = 0;
    aMs = 0; aMr = 0; aBy = 0; aAd = 0; aTopo = 0; aQ = 0;
    for (int l = 0; l < 2; l++) begin mR0[l] = 0; mS0[l] = 0; mS1[l] = 0; mRo[l] = 0; mTo[l] = 0; end
    mSide = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSt = 1; modelClear(); mP[0] = 0; mP[1] = 0; mP[2] = 0;
    end else begin
      bit adv, fl, clr, b2b, ext, used;
      logic [7:0] res0, res1, sig1, q, nR0[2], nS0[2], nS1[2], nRo[2], nTo[2];
      adv = pwrDnN && mSt == 3 && framePulse;
      fl  = adv && (rBy != aBy);
      clr = pwrDnN && (mSt == 1 || mSt == 2);
      b2b = (aTopo == 1); ext = (aTopo == 2);
      res0 = core0(mS0[0]);
      sig1 = b2b ? mR0[0] : (ext ? res0 : mS0[1]);
      res1 = core1(sig1);
      q = aQ;
      if (clr) begin
        modelClear();
        mP[0] = 0; mP[1] = 0; mP[2] = 0;
      end else if (pwrDnN && mSt == 3) begin
        if (adv) begin
          for (int l = 0; l < 2; l++) begin
            logic [7:0] recvV, sendP;
            used = (l == 0) || (!b2b && !ext);
            recvV = (l == 0 && b2b && !aBy) ? res1 : mR0[l];
            sendP = (l == 0) ? (ext ? res1 : res0) : res1;
            nRo[l] = (fl || !used || aMr) ? q : recvV;
            nTo[l] = (fl || !used || aMs) ? q : (aBy ? mS0[l] : mS1[l]);
            nS1[l] = (fl || !used) ? q : sendP;
            nR0[l] = fl ? q : rxIn[l*8 +: 8];
            nS0[l] = fl ? q : txIn[l*8 +: 8];
          end
          for (int l = 0; l < 2; l++) begin
            mRo[l] = nRo[l]; mTo[l] = nTo[l]; mS1[l] = nS1[l]; mR0[l] = nR0[l]; mS0[l] = nS0[l];
          end
          mSide = sideIn;
          aMs = rMs; aMr = rMr; aBy = rBy; aAd = rAd; aTopo = rTopo; aQ = rQ;
        end
        if (cfgWe) begin
          rMs = cfgMuteSend; rMr = cfgMuteRecv; rBy = cfgBypass; rAd = cfgAdaptOff;
          rTopo = cfgTopo; rQ = cfgQuiet;
        end
        mP[2] = mP[1]; mP[1] = mP[0]; mP[0] = adv;
      end
      if (!pwrDnN) mSt = 0;
      else if (mSt == 0) mSt = 1;
      else if (mSt == 1 && framePulse) mSt = 2;
      else if (mSt == 2 && framePulse) mSt = 3;
    end
  end

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit eOe, b2b, ext;
      logic [7:0] res0, ref1, sig1;
      eOe = pwrDnN && mSt == 3;
      b2b = (aTopo == 1); ext = (aTopo == 2);
      res0 = core0(mS0[0]);
      ref1 = b2b ? mS0[0] : (ext ? mR0[0] : mR0[1]);
      sig1 = b2b ? mR0[0] : (ext ? res0 : mS0[1]);
      chk("R8 R9 dataOe", 32'(dataOe), 32'(eOe));
      chk("R12 fpOutN", 32'(fpOutN), 32'(!(eOe && mP[0])));
      chk("R12 tsOutN", 32'(tsOutN), 32'({!(eOe && mP[2]), !(eOe && mP[1])}));
      chk("R11 R6 coreAdaptOff", 32'(coreAdaptOff), 32'(aAd));
      chk("R10 coreRef", 32'(coreRef), 32'({ref1, mR0[0]}));
      chk("R10 coreSig", 32'(coreSig), 32'({sig1, mS0[0]}));
      if (eOe) begin
        chk("R1 R3 R5 R10 rxOut", 32'(rxOut), 32'({mRo[1], mRo[0]}));
        chk("R2 R3 R4 R5 R6 txOut", 32'(txOut), 32'({mTo[1], mTo[0]}));
        chk("R7 sideOut", 32'(sideOut), 32'(mSide));
      end
    end
  end

  task automatic wr(input bit ms, input bit mr, input bit by, input bit ad,
                    input logic [1:0] tp, input logic [7:0] q);
    @(posedge clk); #1;
    cfgMuteSend = ms; cfgMuteRecv = mr; cfgBypass = by; cfgAdaptOff = ad;
    cfgTopo = tp; cfgQuiet = q; cfgWe = 1;
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic waitFrames(input int n);
    repeat (n * 8) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    chk("R9 reset dataOe", 32'(dataOe), 32'(0));
    chk("R9 reset fpOutN", 32'(fpOutN), 32'(1));
    wr(0, 0, 1, 1, 2'd2, 8'h77);             // ignored during initialisation
    waitFrames(3);
    @(negedge clk);
    chk("R9 write ignored adapt", 32'(coreAdaptOff), 32'(0));
    chk("R9 write ignored oe", 32'(dataOe), 32'(1));
    waitFrames(6);
    wr(1, 0, 0, 0, 2'd0, 8'hA5);
    waitFrames(4);
    @(negedge clk);
    chk("R5 mute send", 32'(txOut), 32'(16'hA5A5));
    wr(0, 1, 0, 0, 2'd0, 8'hA5);
    waitFrames(4);
    @(negedge clk);
    chk("R5 mute recv", 32'(rxOut), 32'(16'hA5A5));
    wr(0, 0, 1, 0, 2'd0, 8'h3C);
    waitFrames(5);
    wr(0, 0, 0, 0, 2'd0, 8'h3C);
    waitFrames(5);
    wr(0, 0, 0, 1, 2'd1, 8'h00);
    waitFrames(6);
    wr(0, 0, 1, 0, 2'd1, 8'h00);
    waitFrames(4);
    wr(0, 0, 0, 0, 2'd2, 8'h00);
    waitFrames(6);
    wr(0, 0, 0, 0, 2'd3, 8'h00);
    waitFrames(4);
    wr(0, 0, 0, 1, 2'd2, 8'h5C);
    @(posedge clk); #1 pwrDnN = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R8 pd oe", 32'(dataOe), 32'(0));
    chk("R8 pd fpOutN", 32'(fpOutN), 32'(1));
    chk("R8 pd tsOutN", 32'(tsOutN), 32'(2'b11));
    @(posedge clk); #1 pwrDnN = 1;
    waitFrames(3);
    @(negedge clk);
    chk("R9 defaults after release", 32'(coreAdaptOff), 32'(0));
    waitFrames(5);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule